// File: doc/BRIEF.md
# Programmable Counter/Timer

This block is a 16-bit down counter with two modes of use. A processor writes a 16-bit preload as two bytes and then starts or stops the block by reading two command addresses. No data is written for these commands. Counting advances on a clock-enable input. A select input can divide that enable by 16 first.

In timer mode the block runs without end and drives a square wave. The square-wave period is twice the preload, counted in steps. A ready flag is raised once per period. In counter mode the block counts down once from the preload. It flags terminal count and pulls its output low at that point. It then keeps counting, wrapping past zero, until it is stopped. In counter mode the live count can be read back as two bytes.

Top module: `ct_timer`

## Requirements
- R1: After reset `sqOut` is 1, `ready` is 0 and nothing counts. Enabled ticks, preload writes and changes of mode or prescale leave both outputs unchanged until the first start command, which is a read (`rdEn`=1) at address 0xE.
- R2: A preload write with `wrHigh`=1 stores `wrData` as bits 15:8, and with `wrHigh`=0 as bits 7:0. A counter-mode start shows the whole 16-bit value on the count readback. The preload itself never appears on `rdData`.
- R3: In timer mode (`modeSel`=0), `sqOut` is 1 after a start and inverts every P steps, where P is the preload. It keeps doing so without further commands.
- R4: In timer mode, `ready` is set each time `sqOut` returns from 0 to 1, which is once every 2·P steps.
- R5: In timer mode a stop command, which is a read at 0xF, clears `ready` on the next edge. The square wave keeps its timing.
- R6: A start command in either mode abandons the current cycle. On the next edge it sets `sqOut` to 1, clears `ready`, loads the count from the preload and clears the prescaler.
- R7: In timer mode a preload written during a half-period does not change that half-period. Every half-period that begins later uses the new value.
- R8: In counter mode (`modeSel`=1) the count drops by one per step. When it reaches 0x0000, `ready` is set and `sqOut` goes to 0. The count goes on to 0xFFFF and keeps counting.
- R9: In counter mode a stop command freezes the count, sets `sqOut` to 1 and clears `ready`.
- R10: In counter mode a preload written while counting leaves the count unchanged. The next start uses the last preload written, and a start with no new write reuses the old value.
- R11: A step happens on each cycle with `tickEn`=1 when `preSel`=0. When `preSel`=1, a step happens on every 16th such cycle after a start. A cycle with `tickEn`=0 causes no step.
- R12: `rdData` shows count bits 15:8 at address 0xC and bits 7:0 at address 0xD, but only in counter mode. It is 0 for every other address and for both addresses in timer mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Count clock enable |
| preSel | input | 1 | 1 = divide tickEn by 16 |
| modeSel | input | 1 | 0 = timer, 1 = counter |
| wrEn | input | 1 | Preload byte write strobe |
| wrHigh | input | 1 | 1 = upper preload byte, 0 = lower |
| wrData | input | 8 | Preload byte |
| rdEn | input | 1 | Read strobe; at 0xE starts, at 0xF stops |
| rdAddr | input | 4 | Read address |
| rdData | output | 8 | Count byte readback |
| sqOut | output | 1 | Square wave or terminal-count output |
| ready | output | 1 | Ready flag |

## Verification
The assertions assume three things about the inputs. `modeSel` changes only in the same cycle as a start command. The preload is at least 2 whenever a start is issued. The bench follows both rules: every run sets the mode together with its start read and writes a legal preload first. The only mid-run preload changes it makes are deliberate ones that stay at or above 2. The bench also times its stop commands so that none lands on the edge where timer mode sets `ready`. On that edge, stop takes priority.

// File: rtl/ct_timer_pkg.sv
package ct_timer_pkg;

  typedef enum logic {
    MODE_TIMER   = 1'b0,
    MODE_COUNTER = 1'b1
  } ctMode_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic outHigh;
    logic outLow;
    logic outToggle;
    logic setRdy;
    logic clrRdy;
  } ctStrobe_t;

endpackage

// File: rtl/ct_timer_ctrl.sv
module ct_timer_ctrl
  import ct_timer_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] ADDR_START = 'hE,
  parameter logic [ADDR_W-1:0] ADDR_STOP  = 'hF,
  parameter int PRE_DIV = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              preSel,
  input  logic              modeSel,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              cntIsOne,
  input  logic              outLvl,
  output ctStrobe_t         strb,
  output logic              countVisible
);

  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  ctMode_e mode;
  logic running;
  logic [PRE_W-1:0] preCnt;
  logic startCmd, stopCmd, step;

  assign mode     = ctMode_e'(modeSel);
  assign startCmd = rdEn && (rdAddr == ADDR_START);
  assign stopCmd  = rdEn && (rdAddr == ADDR_STOP);
  assign step     = running && tickEn && (!preSel || (preCnt == PRE_LAST));
  assign countVisible = (mode == MODE_COUNTER);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      preCnt  <= '0;
    end else begin
      if (startCmd) begin
        running <= 1'b1;
        preCnt  <= '0;
      end else begin
        if (stopCmd && (mode == MODE_COUNTER)) running <= 1'b0;
        if (running && tickEn && preSel)
          preCnt <= (preCnt == PRE_LAST) ? '0 : preCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb = '0;
    if (startCmd) begin
      strb.loadCnt = 1'b1;
      strb.outHigh = 1'b1;
      strb.clrRdy  = 1'b1;
    end else if (mode == MODE_COUNTER) begin
      if (stopCmd) begin
        strb.clrRdy  = 1'b1;
        strb.outHigh = 1'b1;
      end else if (step) begin
        strb.decCnt = 1'b1;
        if (cntIsOne) begin
          strb.setRdy = 1'b1;
          strb.outLow = 1'b1;
        end
      end
    end else begin
      if (step) begin
        if (cntIsOne) begin
          strb.loadCnt   = 1'b1;
          strb.outToggle = 1'b1;
          strb.setRdy    = !outLvl;
        end else begin
          strb.decCnt = 1'b1;
        end
      end
      if (stopCmd) strb.clrRdy = 1'b1;
    end
  end

endmodule

// File: rtl/ct_timer_dp.sv
module ct_timer_dp
  import ct_timer_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] ADDR_CNT_HI = 'hC,
  parameter logic [ADDR_W-1:0] ADDR_CNT_LO = 'hD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrHigh,
  input  logic [BYTE_W-1:0] wrData,
  input  ctStrobe_t         strb,
  input  logic              countVisible,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BYTE_W-1:0] rdData,
  output logic              cntIsOne,
  output logic              outLvl,
  output logic              ready
);

  localparam int CNT_W = 2 * BYTE_W;
  localparam int NBYTE = 2;

  logic [BYTE_W-1:0] preByte [NBYTE];
  logic [CNT_W-1:0]  preAll;
  logic [CNT_W-1:0]  count;

  for (genvar b = 0; b < NBYTE; b++) begin : g_pre
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                             preByte[b] <= '0;
      else if (wrEn && (wrHigh == (b == 1))) preByte[b] <= wrData;
    end
  end

  assign preAll   = {preByte[1], preByte[0]};
  assign cntIsOne = (count == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      outLvl <= 1'b1;
      ready  <= 1'b0;
    end else begin
      if (strb.loadCnt)     count <= preAll;
      else if (strb.decCnt) count <= count - 1'b1;

      if (strb.outHigh)        outLvl <= 1'b1;
      else if (strb.outLow)    outLvl <= 1'b0;
      else if (strb.outToggle) outLvl <= !outLvl;

      if (strb.clrRdy)      ready <= 1'b0;
      else if (strb.setRdy) ready <= 1'b1;
    end
  end

  always_comb begin
    rdData = '0;
    if (countVisible) begin
      if (rdAddr == ADDR_CNT_HI)      rdData = count[CNT_W-1 -: BYTE_W];
      else if (rdAddr == ADDR_CNT_LO) rdData = count[BYTE_W-1:0];
    end
  end

endmodule

// File: rtl/ct_timer.sv
module ct_timer
  import ct_timer_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] ADDR_START  = 'hE,
  parameter logic [ADDR_W-1:0] ADDR_STOP   = 'hF,
  parameter logic [ADDR_W-1:0] ADDR_CNT_HI = 'hC,
  parameter logic [ADDR_W-1:0] ADDR_CNT_LO = 'hD,
  parameter int PRE_DIV = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              preSel,
  input  logic              modeSel,
  input  logic              wrEn,
  input  logic              wrHigh,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BYTE_W-1:0] rdData,
  output logic              sqOut,
  output logic              ready
);

  ctStrobe_t strb;
  logic cntIsOne, outLvl, countVisible;

  ct_timer_ctrl #(
    .ADDR_W(ADDR_W), .ADDR_START(ADDR_START), .ADDR_STOP(ADDR_STOP), .PRE_DIV(PRE_DIV)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .preSel(preSel), .modeSel(modeSel),
    .rdEn(rdEn), .rdAddr(rdAddr), .cntIsOne(cntIsOne), .outLvl(outLvl),
    .strb(strb), .countVisible(countVisible)
  );

  ct_timer_dp #(
    .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .ADDR_CNT_HI(ADDR_CNT_HI), .ADDR_CNT_LO(ADDR_CNT_LO)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrHigh(wrHigh), .wrData(wrData),
    .strb(strb), .countVisible(countVisible), .rdAddr(rdAddr), .rdData(rdData),
    .cntIsOne(cntIsOne), .outLvl(outLvl), .ready(ready)
  );

  assign sqOut = outLvl;

endmodule

// File: rtl/ct_timer_chk.sv
module ct_timer_chk #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] ADDR_START = 'hE,
  parameter logic [ADDR_W-1:0] ADDR_STOP  = 'hF
) (
  input logic              clk,
  input logic              rstN,
  input logic              modeSel,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              sqOut,
  input logic              ready
);

  logic startCmd, stopCmd, startedQ;
  assign startCmd = rdEn && (rdAddr == ADDR_START);
  assign stopCmd  = rdEn && (rdAddr == ADDR_STOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         startedQ <= 1'b0;
    else if (startCmd) startedQ <= 1'b1;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !startedQ |-> (sqOut && !ready));

  // R6
  start_rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    startCmd |=> (sqOut && !ready));

  // R5
  timer_stop_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopCmd && !modeSel) |=> !ready);

  // R9
  counter_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopCmd && modeSel) |=> (sqOut && !ready));

  // R4
  timer_ready_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel && $rose(ready)) |-> $rose(sqOut));

  // R8
  counter_tc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel && $fell(sqOut)) |-> ready);

endmodule

bind ct_timer ct_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .rdEn(rdEn),
  .rdAddr(rdAddr), .sqOut(sqOut), .ready(ready)
);

// File: tb/ct_timer_test.sv
module ct_timer_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, preSel = 1'b0, modeSel = 1'b0;
  logic wrEn = 1'b0, wrHigh = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [3:0] rdAddr = '0;
  logic [7:0] rdData;
  logic sqOut, ready;

  int total = 0;
  int bad = 0;
  int benchPre = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ct_timer uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .preSel(preSel), .modeSel(modeSel),
    .wrEn(wrEn), .wrHigh(wrHigh), .wrData(wrData), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .sqOut(sqOut), .ready(ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  task automatic readCount(output int val);
    logic [7:0] lo, hi;
    rdEn = 1'b0;
    rdAddr = 4'hD; #1 lo = rdData;
    rdAddr = 4'hC; #1 hi = rdData;
    val = {hi, lo};
  endtask

  task automatic writePre(input int val);
    @(negedge clk); rdEn = 0; wrEn = 1; wrHigh = 0; wrData = val[7:0];
    @(negedge clk); wrHigh = 1; wrData = val[15:8];
    @(negedge clk); wrEn = 0;
    benchPre = val & 16'hFFFF;
  endtask

  // start at cycle 0, then nCyc cycles checked against an arithmetic model
  task automatic runSeq(input bit mode, input bit ps, input int tickDiv, input int nCyc,
                        input int wrAt, input int wrVal, input int stopAt, input string tag);
    int cnt, preC, rd, expRd;
    bit out, rdy, run, tk, st, step;
    @(negedge clk);
    modeSel = mode; preSel = ps; tickEn = 0; wrEn = 0; rdEn = 1; rdAddr = 4'hE;
    cnt = benchPre; preC = 0; out = 1; rdy = 0; run = 1;
    for (int n = 1; n <= nCyc + 1; n++) begin
      @(negedge clk);
      readCount(rd);
      expRd = mode ? cnt : 0;
      check(sqOut == out, tag, sqOut, out);
      check(ready == rdy, tag, ready, rdy);
      check(rd == expRd, mode ? "R8 count" : "R12 count", rd, expRd);
      if (n == nCyc + 1) break;
      tk = (n % tickDiv) == 0;
      st = (n == stopAt);
      tickEn = tk;
      rdEn = st; rdAddr = 4'hF;
      wrEn = (n == wrAt) || (n == wrAt + 1);
      wrHigh = (n == wrAt + 1);
      wrData = (n == wrAt + 1) ? wrVal[15:8] : wrVal[7:0];
      step = run && tk && (!ps || preC == 15);
      if (run && tk && ps) preC = (preC + 1) % 16;
      if (!mode) begin
        if (step) begin
          if (cnt == 1) begin
            cnt = benchPre; out = !out;
            if (out) rdy = 1;
          end else cnt = cnt - 1;
        end
        if (st) rdy = 0;
      end else begin
        if (st) begin
          run = 0; out = 1; rdy = 0;
        end else if (step) begin
          if (cnt == 1) begin rdy = 1; out = 0; end
          cnt = (cnt - 1) & 16'hFFFF;
        end
      end
      if (n == wrAt) benchPre = (benchPre & 16'hFF00) | (wrVal & 16'h00FF);
      if (n == wrAt + 1) benchPre = (benchPre & 16'h00FF) | (wrVal & 16'hFF00);
    end
    tickEn = 0; rdEn = 0; wrEn = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    int rd;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sqOut == 1, "R1 reset sqOut", sqOut, 1);
    check(ready == 0, "R1 reset ready", ready, 0);
    rstN = 1;
    writePre(5);
    for (int m = 0; m < 2; m++) begin
      modeSel = m[0]; preSel = m[0]; tickEn = 1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        readCount(rd);
        check(sqOut == 1 && ready == 0, "R1 idle before start", {sqOut, ready}, 2);
        check(rd == 0, "R1 no count before start", rd, 0);
      end
    end
    tickEn = 0;
    // R2, R12: preload never readable, other addresses read 0
    writePre(16'h1234);
    for (int m = 0; m < 2; m++) begin
      modeSel = m[0];
      for (int a = 0; a < 16; a++) begin
        rdAddr = a[3:0]; #1;
        check(rdData == 0, "R2 R12 no preload readback", rdData, 0);
      end
    end
    runSeq(1, 0, 1, 4, -1, 0, -1, "R2");
    // R3 R4 timer sweep
    for (int p = 2; p <= 6; p++) begin
      writePre(p);
      runSeq(0, 0, 1, 6 * p + 3, -1, 0, -1, "R3 R4");
    end
    // R11 gated enable and prescale
    writePre(3);
    runSeq(0, 0, 3, 45, -1, 0, -1, "R11 timer");
    writePre(2);
    runSeq(0, 1, 1, 150, -1, 0, -1, "R11 timer /16");
    runSeq(0, 1, 2, 200, -1, 0, -1, "R11 timer /16 gated");
    // R5 stop does not halt timer
    writePre(3);
    runSeq(0, 0, 1, 30, -1, 0, 8, "R5");
    // R6 restart mid low half with ready set
    runSeq(0, 0, 1, 10, -1, 0, -1, "R6");
    runSeq(0, 0, 1, 14, -1, 0, -1, "R6");
    // R7 preload change mid half
    writePre(4);
    runSeq(0, 0, 1, 24, 2, 6, -1, "R7");
    // R8 counter through zero and wrap
    writePre(5);
    runSeq(1, 0, 1, 12, -1, 0, -1, "R8");
    writePre(2);
    runSeq(1, 1, 1, 60, -1, 0, -1, "R11 counter /16");
    // R9 stop freezes counter
    writePre(4);
    runSeq(1, 0, 1, 12, -1, 0, 7, "R9");
    // R10 deferred preload then reuse
    writePre(6);
    runSeq(1, 0, 1, 10, 2, 9, -1, "R10");
    runSeq(1, 0, 1, 4, -1, 0, -1, "R10 new value");
    runSeq(1, 0, 1, 4, -1, 0, -1, "R10 reuse");
    finishRun();
  end

endmodule